// File: doc/BRIEF.md
# Motorized Door Controller

This block sequences a motor-driven door from a handful of discrete field signals: a pushbutton, an emergency-stop-healthy level, a closed-end and an open-end limit switch, an overtravel switch and a motor-fault contact. It drives a motor-run level, a direction level and a fault flag. It also presents its one-hot state as a status vector. Its inputs are assumed to be debounced and synchronised to `clk` already.

After reset the door position is unknown. The controller reads the limit switches to settle on fully open or fully closed. From either end, and from a halt in mid-travel, a fresh press of the pushbutton starts motion, provided the emergency stop is healthy and the stopped state has dwelt long enough. The dwell prevents short cycling of the motor. While the door moves, a limit switch, another press or loss of the emergency stop halts it. The overtravel and motor-fault inputs latch a fault state that only reset clears. The state register is one-hot, and the next state depends only on the current state and the inputs. A clock edge therefore moves the controller at most one step.

Top module: `door_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the controller in the unknown-position state (`state_o` = 8'h01). The controller then shows `motor_run_o`, `dir_up_o` and `fault_o` all 0. The state bits are: bit0 unknown, bit1 fully open, bit2 travelling down, bit3 fully closed, bit4 travelling up, bit5 stopped mid-travel, bit6 overtravel fault, bit7 motor fault.
- R2: In the unknown-position state, the controller picks its next state from the limit switches:
  - closed limit active and open limit inactive: fully closed;
  - open limit active and closed limit inactive: fully open;
  - both limits active: overtravel fault;
  - neither limit active: it stays unknown.
- R3: From fully open, the controller moves to travelling down at a clock edge only when all three of these hold:
  - the pushbutton has a rising edge, meaning it is 1 now and was 0 at the previous clock edge;
  - `estop_ok_i` is 1;
  - the dwell has expired.
  
  A held pushbutton gives no further edge.
- R4: From fully closed, the controller moves to travelling up under the same three conditions as R3.
- R5: While travelling down, the closed limit leads to fully closed. While travelling up, the open limit leads to fully open.
- R6: During travel, a pushbutton rising edge leads to the stopped-mid-travel state. So does `estop_ok_i` = 0.
- R7: From stopped mid-travel, the controller resumes motion opposite to the direction it last travelled. This needs a pushbutton rising edge, `estop_ok_i` = 1 and an expired dwell.
- R8: Each entry into fully open, fully closed or stopped mid-travel reloads the dwell count to DWELL_CYC. The count falls by one per clock. A motion command is accepted no earlier than the DWELL_CYC+1-th clock edge after the entering edge, and an earlier press is ignored.
- R9: In a travel state, `motor_fault_i` leads to the motor-fault state, and otherwise `overtravel_i` leads to the overtravel-fault state. Both fault states are left only by reset.
- R10: The outputs are decoded from the current state:
  - `motor_run_o` is 1 only while travelling down or up;
  - `dir_up_o` is 1 only while travelling up;
  - `fault_o` is 1 only in the two fault states.
- R11: Exactly one state bit is set at all times after reset, and a clock edge makes at most one state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Pushbutton level |
| estop_ok_i | input | 1 | Emergency stop healthy |
| lim_closed_i | input | 1 | Closed-end limit switch |
| lim_open_i | input | 1 | Open-end limit switch |
| overtravel_i | input | 1 | Overtravel switch |
| motor_fault_i | input | 1 | Motor fault contact |
| motor_run_o | output | 1 | Motor energised |
| dir_up_o | output | 1 | Direction, 1 = up |
| fault_o | output | 1 | Latched fault present |
| state_o | output | 8 | One-hot state (see R1) |

## Verification
Every input set is consumed at exactly one clock edge, and `state_o`, `motor_run_o`, `dir_up_o` and `fault_o` show the result straight after that edge, with no further register stage. The bench drives inputs on the falling edge and compares all outputs on the next falling edge, so each check sees the effect of exactly one edge. Dwell expectations are counted in edges from the entering edge. The vector table places presses one edge before and exactly at the DWELL_CYC+1-th edge to pin the boundary.

// File: rtl/door_pkg.sv
package door_pkg;
  localparam int NUM_ST   = 8;
  localparam int ST_UNK   = 0;
  localparam int ST_OPEN  = 1;
  localparam int ST_DOWN  = 2;
  localparam int ST_CLOSE = 3;
  localparam int ST_UP    = 4;
  localparam int ST_STOP  = 5;
  localparam int ST_OVT   = 6;
  localparam int ST_MFLT  = 7;

  typedef logic [NUM_ST-1:0] state_t;

  function automatic state_t st_oh(int idx);
    state_t r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/door_edge.sv
module door_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/door_dwell.sv
module door_dwell #(
  parameter int DWELL_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = $clog2(DWELL_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DWELL_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/door_fsm.sv
module door_fsm
  import door_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   rise_i,
  input  logic   estop_ok_i,
  input  logic   lim_closed_i,
  input  logic   lim_open_i,
  input  logic   overtravel_i,
  input  logic   motor_fault_i,
  input  logic   dwell_done_i,
  output logic   dwell_load_o,
  output state_t state_o
);
  state_t st_q, st_d;
  logic   last_up_q;
  logic   go;

  assign go = rise_i & estop_ok_i & dwell_done_i;

  always_comb begin
    st_d = st_q;
    if (st_q[ST_UNK]) begin
      if (lim_closed_i && lim_open_i) st_d = st_oh(ST_OVT);
      else if (lim_closed_i)          st_d = st_oh(ST_CLOSE);
      else if (lim_open_i)            st_d = st_oh(ST_OPEN);
    end else if (st_q[ST_OPEN]) begin
      if (go) st_d = st_oh(ST_DOWN);
    end else if (st_q[ST_CLOSE]) begin
      if (go) st_d = st_oh(ST_UP);
    end else if (st_q[ST_STOP]) begin
      if (go) st_d = last_up_q ? st_oh(ST_DOWN) : st_oh(ST_UP);
    end else if (st_q[ST_DOWN] || st_q[ST_UP]) begin
      if (motor_fault_i)                   st_d = st_oh(ST_MFLT);
      else if (overtravel_i)               st_d = st_oh(ST_OVT);
      else if (!estop_ok_i)                st_d = st_oh(ST_STOP);
      else if (st_q[ST_DOWN] && lim_closed_i) st_d = st_oh(ST_CLOSE);
      else if (st_q[ST_UP] && lim_open_i)     st_d = st_oh(ST_OPEN);
      else if (rise_i)                     st_d = st_oh(ST_STOP);
    end
  end

  assign dwell_load_o = (st_d != st_q) &&
                        (st_d[ST_OPEN] || st_d[ST_CLOSE] || st_d[ST_STOP]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= st_oh(ST_UNK);
      last_up_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q[ST_UP])        last_up_q <= 1'b1;
      else if (st_q[ST_DOWN]) last_up_q <= 1'b0;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/door_ctrl.sv
module door_ctrl
  import door_pkg::*;
#(
  parameter int DWELL_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn_i,
  input  logic              estop_ok_i,
  input  logic              lim_closed_i,
  input  logic              lim_open_i,
  input  logic              overtravel_i,
  input  logic              motor_fault_i,
  output logic              motor_run_o,
  output logic              dir_up_o,
  output logic              fault_o,
  output logic [NUM_ST-1:0] state_o
);
  logic   rise, dwell_load, dwell_done;
  state_t st;

  door_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (btn_i),
    .rise_o (rise)
  );

  door_dwell #(.DWELL_CYC(DWELL_CYC)) u_dwell (
    .clk    (clk),
    .rst    (rst),
    .load_i (dwell_load),
    .done_o (dwell_done)
  );

  door_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .rise_i        (rise),
    .estop_ok_i    (estop_ok_i),
    .lim_closed_i  (lim_closed_i),
    .lim_open_i    (lim_open_i),
    .overtravel_i  (overtravel_i),
    .motor_fault_i (motor_fault_i),
    .dwell_done_i  (dwell_done),
    .dwell_load_o  (dwell_load),
    .state_o       (st)
  );

  assign motor_run_o = st[ST_DOWN] | st[ST_UP];
  assign dir_up_o    = st[ST_UP];
  assign fault_o     = st[ST_OVT] | st[ST_MFLT];
  assign state_o     = st;
endmodule

// File: rtl/door_ctrl_chk.sv
module door_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       estop_ok_i,
  input logic       lim_closed_i,
  input logic       lim_open_i,
  input logic       motor_fault_i,
  input logic       motor_run_o,
  input logic       fault_o,
  input logic [7:0] state_o
);
  logic moving;
  assign moving = state_o[2] | state_o[4];

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(state_o) == 1);                                        // R11
  AST_UNK_BOTH_LIM: assert property (@(posedge clk) disable iff (rst)
    (state_o[0] && lim_closed_i && lim_open_i) |=> state_o[6]);       // R2
  AST_OPEN_EXIT: assert property (@(posedge clk) disable iff (rst)
    state_o[1] |=> (state_o[1] || state_o[2]));                       // R3
  AST_CLOSED_EXIT: assert property (@(posedge clk) disable iff (rst)
    state_o[3] |=> (state_o[3] || state_o[4]));                       // R4
  AST_ESTOP_HALT: assert property (@(posedge clk) disable iff (rst)
    (moving && !estop_ok_i && !motor_fault_i && !fault_o) |=> !motor_run_o); // R6
  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(state_o[5]) |=> state_o[5]);                                // R8
  AST_MFAULT_TRIP: assert property (@(posedge clk) disable iff (rst)
    (moving && motor_fault_i) |=> state_o[7]);                        // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o);                                             // R9
  AST_RUN_NOT_FAULT: assert property (@(posedge clk) disable iff (rst)
    motor_run_o |-> !fault_o);                                        // R10
endmodule

bind door_ctrl door_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .estop_ok_i    (estop_ok_i),
  .lim_closed_i  (lim_closed_i),
  .lim_open_i    (lim_open_i),
  .motor_fault_i (motor_fault_i),
  .motor_run_o   (motor_run_o),
  .fault_o       (fault_o),
  .state_o       (state_o)
);

// File: tb/tb_door_ctrl.sv
module tb_door_ctrl;
  localparam int DW = 3;
  localparam int NV = 30;
  localparam logic [7:0] U = 8'h01, O = 8'h02, D = 8'h04, C = 8'h08,
                         P = 8'h10, S = 8'h20, T = 8'h40, M = 8'h80;

  // {btn, estop_ok, lim_closed, lim_open, overtravel, motor_fault, expected state}
  localparam logic [13:0] VEC [NV] = '{
    {6'b010000, U}, {6'b011000, C}, {6'b111000, C}, {6'b011000, C},
    {6'b111000, C}, {6'b011000, C}, {6'b101000, C}, {6'b111000, C},
    {6'b011000, C}, {6'b111000, P}, {6'b110000, P}, {6'b010000, P},
    {6'b010100, O}, {6'b110100, O}, {6'b010100, O}, {6'b010100, O},
    {6'b010100, O}, {6'b110100, D}, {6'b010000, D}, {6'b110000, S},
    {6'b010000, S}, {6'b110000, S}, {6'b010000, S}, {6'b110000, P},
    {6'b000000, S}, {6'b010000, S}, {6'b010000, S}, {6'b010000, S},
    {6'b110000, D}, {6'b011000, C}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn, eok, lc, lo, ot, mf;
  logic motor_run_o, dir_up_o, fault_o;
  logic [7:0] state_o;
  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  door_ctrl #(.DWELL_CYC(DW)) dut (
    .clk(clk), .rst(rst), .btn_i(btn), .estop_ok_i(eok),
    .lim_closed_i(lc), .lim_open_i(lo), .overtravel_i(ot),
    .motor_fault_i(mf), .motor_run_o(motor_run_o), .dir_up_o(dir_up_o),
    .fault_o(fault_o), .state_o(state_o)
  );

  function automatic string vec_req(int i);
    if (i <= 1)  return "R2";
    if (i <= 8)  return "R8";
    if (i <= 11) return "R4";
    if (i <= 16) return "R5";
    if (i <= 18) return "R3";
    if (i <= 27) return "R7";
    return "R5";
  endfunction

  task automatic check(string req, logic [7:0] exp);
    logic er, ed, ef;
    er = exp[2] | exp[4];
    ed = exp[4];
    ef = exp[6] | exp[7];
    applied++;
    if (state_o !== exp) begin
      errors++;
      $display("FAIL %s state: got %h expected %h", req, state_o, exp);
    end
    if ({motor_run_o, dir_up_o, fault_o} !== {er, ed, ef}) begin
      errors++;
      $display("FAIL R10 (%s) run/dir/fault: got %b expected %b",
               req, {motor_run_o, dir_up_o, fault_o}, {er, ed, ef});
    end
    if ($countones(state_o) != 1) begin
      errors++;
      $display("FAIL R11 one-hot: got %h expected one bit", state_o);
    end
  endtask

  task automatic apply(logic [5:0] in, string req, logic [7:0] exp);
    {btn, eok, lc, lo, ot, mf} = in;
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {btn, eok, lc, lo, ot, mf} = 6'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", U);
    rst = 1'b0;
  endtask

  task automatic idle(logic [5:0] in, int n, string req, logic [7:0] exp);
    for (int k = 0; k < n; k++) apply(in, req, exp);
  endtask

  initial begin
    {btn, eok, lc, lo, ot, mf} = 6'b0;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) apply(VEC[i][13:8], vec_req(i), VEC[i][7:0]);

    // R2: both limits in unknown state -> overtravel; R9 stays faulted
    do_reset();
    apply(6'b011100, "R2", T);
    idle(6'b010000, 2, "R9", T);
    do_reset();

    // R9: motor fault wins over overtravel while travelling up
    apply(6'b011000, "R2", C);
    idle(6'b011000, DW, "R8", C);
    apply(6'b111000, "R4", P);
    apply(6'b010011, "R9", M);
    apply(6'b010000, "R9", M);
    apply(6'b110100, "R9", M);
    do_reset();

    // R9: overtravel while travelling down
    apply(6'b010100, "R2", O);
    idle(6'b010100, DW, "R8", O);
    apply(6'b110100, "R3", D);
    apply(6'b010010, "R9", T);
    apply(6'b011000, "R9", T);

    // R6: estop loss halts travel down
    do_reset();
    apply(6'b010100, "R2", O);
    idle(6'b010100, DW, "R8", O);
    apply(6'b110100, "R3", D);
    apply(6'b100000, "R6", S);
    do_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule